// File: doc/BRIEF.md
# Tiled resource translation table walker

This block sits in front of a page-table stage and turns a 48-bit graphics virtual address into an intermediate virtual address when the address falls inside a reserved translation segment. The segment is one sixteenth of the address space (2^44 bytes). It is selected by a masked compare of the address's top nibble against a configured select value. An address inside the segment is resolved by walking a three-level table of 64KB tiles held in memory. The top and middle levels hold 64-bit entries that point at 4KB table pages. The leaf level holds 32-bit entries that name the backing tile. Any address that misses the segment, or arrives while translation is switched off, leaves the block unchanged.

Each table entry is compared against two programmable 32-bit patterns. One pattern marks an unbound region and the other marks a hole in a sparse resource. A match at any level stops the walk. Only one request is in flight at a time. The table read port accepts a one-cycle read strobe and tolerates any response delay.

The walker is a single state machine with these states: `S_IDLE` (ready for a request), `S_L3_FETCH`/`S_L3_WAIT`, `S_L2_FETCH`/`S_L2_WAIT`, `S_L1_FETCH`/`S_L1_WAIT` (issue one table read, then hold until its data returns), and `S_RESP` (present the result for one cycle). The transitions are as follows:
- `S_IDLE` goes to `S_L3_FETCH` on a request that hits the segment, and to `S_RESP` on any other request.
- Each FETCH state goes to its WAIT state.
- A WAIT state goes to the next level's FETCH state when the entry is usable. It goes to `S_RESP` on a pattern match, and `S_L1_WAIT` also goes to `S_RESP` when it finishes.
- `S_RESP` returns to `S_IDLE`.

Top module: `tile_xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_en` are 0.
- R2: When `cfg_enable` or `cfg_tables_virt` is 0, or the segment compare misses, the response has `rsp_pass`=1 and `rsp_addr` equal to the request address, and no table read is issued.
- R3: An address hits the segment when (addr[47:44] & `cfg_seg_mask`) equals (`cfg_seg_sel` & `cfg_seg_mask`), with both enables set. A mask of 4'hF compares the whole nibble, and a mask of 0 matches every address.
- R4: The first read of a walk is at byte address {`cfg_l3_page`, 16'h0} + addr[43:35]×8.
- R5: The next table base is entry[47:12] followed by twelve zero bits. The second read is at base + addr[34:26]×8 and the third read is at base + addr[25:16]×4. Reads at the 64-bit levels are 8-byte aligned.
- R6: The read port returns the 64-bit doubleword that holds the addressed byte. The leaf entry is data[63:32] when bit 2 of the leaf read address is 1, and data[31:0] otherwise. The other half has no effect.
- R7: A completed walk responds with `rsp_xlat`=1 and `rsp_addr` = {leaf entry, addr[15:0]}.
- R8: If the compared entry word equals `cfg_inval_pat` at any level, the walk ends with `rsp_inval`=1 and `rsp_addr`=0, and no further read is issued. At the 64-bit levels the compared word is entry[31:0]. When both patterns match, the invalid result takes priority.
- R9: If the compared entry word equals `cfg_null_pat`, and not the invalid pattern, the walk ends with `rsp_null`=1 and `rsp_addr`=0, and no further read is issued.
- R10: `req_ready` is low from the cycle after acceptance until after the one-cycle `rsp_valid` pulse. Exactly one result flag is set in each response.
- R11: Each table read is a single-cycle `mem_rd_en` pulse. Its data is taken on any later cycle in which `mem_rsp_valid` is 1, whatever the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Translation enable |
| cfg_tables_virt | input | 1 | Tables live in virtual space; required for translation |
| cfg_l3_page | input | 32 | Top-level table address in 64KB units |
| cfg_seg_sel | input | 4 | Segment select value |
| cfg_seg_mask | input | 4 | Bits of the select value that take part in the compare |
| cfg_null_pat | input | 32 | Entry pattern that marks a hole |
| cfg_inval_pat | input | 32 | Entry pattern that marks an unbound region |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 48 | Input virtual address |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_addr | output | 48 | Result address |
| rsp_pass | output | 1 | Address was not translated |
| rsp_xlat | output | 1 | Address was translated |
| rsp_null | output | 1 | Walk ended on the hole pattern |
| rsp_inval | output | 1 | Walk ended on the unbound pattern |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 48 | Table read byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Doubleword holding the addressed entry |

## Verification
The hardest cases to reach are walks that stop partway: a pattern hit on the second-level entry, or on one half of a leaf doubleword while the other half stays live. The bench memory builds every table entry arithmetically from its address. On top of that it overlays one doubleword at the computed address of a chosen level's entry, so each pattern can be placed at each level and in each leaf half. The number of reads is then checked to show that the walk stopped. A segment sweep covers all 256 select/nibble pairs, and a second phase stretches the read latency.

// File: rtl/tile_xlate_pkg.sv
package tile_xlate_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L3_FETCH,
        S_L3_WAIT,
        S_L2_FETCH,
        S_L2_WAIT,
        S_L1_FETCH,
        S_L1_WAIT,
        S_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        LV_L3,
        LV_L2,
        LV_L1
    } tbl_level_e;

    typedef enum logic [1:0] {
        RK_PASS,
        RK_XLAT,
        RK_NULL,
        RK_INVAL
    } result_kind_e;

endpackage

// File: rtl/tx_seg_match.sv
module tx_seg_match #(
    parameter int VA_W  = 48,
    parameter int SEL_W = 4
) (
    input  logic [VA_W-1:0]  va,
    input  logic             xlat_on,
    input  logic [SEL_W-1:0] sel,
    input  logic [SEL_W-1:0] mask,
    output logic             hit
);
    localparam int TOP_LSB = VA_W - SEL_W;

    assign hit = xlat_on && ((va[VA_W-1:TOP_LSB] & mask) == (sel & mask));

endmodule

// File: rtl/tx_fetch_addr.sv
module tx_fetch_addr
    import tile_xlate_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int OFF_W = 16,
    parameter int L3_W  = 9,
    parameter int L2_W  = 9,
    parameter int L1_W  = 10
) (
    input  tbl_level_e        lvl,
    input  logic [VA_W-OFF_W-1:0] root_page,
    input  logic [VA_W-1:0]   tbl_base,
    input  logic [VA_W-1:0]   va,
    output logic [VA_W-1:0]   fetch_addr
);
    localparam int L1_LSB = OFF_W;
    localparam int L2_LSB = L1_LSB + L1_W;
    localparam int L3_LSB = L2_LSB + L2_W;

    logic [VA_W-1:0] root_base;
    logic [VA_W-1:0] off_wide;
    logic [VA_W-1:0] off_mid;
    logic [VA_W-1:0] off_leaf;

    assign root_base = {root_page, {OFF_W{1'b0}}};
    assign off_wide  = VA_W'(va[L3_LSB +: L3_W]) << 3;
    assign off_mid   = VA_W'(va[L2_LSB +: L2_W]) << 3;
    assign off_leaf  = VA_W'(va[L1_LSB +: L1_W]) << 2;

    always_comb begin
        case (lvl)
            LV_L3:   fetch_addr = root_base + off_wide;
            LV_L2:   fetch_addr = tbl_base + off_mid;
            LV_L1:   fetch_addr = tbl_base + off_leaf;
            default: fetch_addr = '0;
        endcase
    end

endmodule

// File: rtl/tx_entry_check.sv
module tx_entry_check #(
    parameter int VA_W  = 48,
    parameter int PAT_W = 32,
    parameter int ENT_W = 64,
    parameter int PG_SH = 12
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_leaf,
    input  logic             hi_half,
    input  logic [PAT_W-1:0] null_pat,
    input  logic [PAT_W-1:0] inval_pat,
    output logic [PAT_W-1:0] word,
    output logic             hit_inval,
    output logic             hit_null,
    output logic [VA_W-1:0]  next_base
);
    assign word      = (is_leaf && hi_half) ? entry[2*PAT_W-1:PAT_W] : entry[PAT_W-1:0];
    assign hit_inval = (word == inval_pat);
    assign hit_null  = !hit_inval && (word == null_pat);
    assign next_base = {entry[VA_W-1:PG_SH], {PG_SH{1'b0}}};

endmodule

// File: rtl/tile_xlate_walker.sv
module tile_xlate_walker
    import tile_xlate_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int OFF_W = 16,
    parameter int L3_W  = 9,
    parameter int L2_W  = 9,
    parameter int L1_W  = 10,
    parameter int SEL_W = 4,
    parameter int PAT_W = 32,
    parameter int ENT_W = 64,
    parameter int PG_SH = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_enable,
    input  logic                  cfg_tables_virt,
    input  logic [VA_W-OFF_W-1:0] cfg_l3_page,
    input  logic [SEL_W-1:0]      cfg_seg_sel,
    input  logic [SEL_W-1:0]      cfg_seg_mask,
    input  logic [PAT_W-1:0]      cfg_null_pat,
    input  logic [PAT_W-1:0]      cfg_inval_pat,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_addr,
    output logic                  rsp_valid,
    output logic [VA_W-1:0]       rsp_addr,
    output logic                  rsp_pass,
    output logic                  rsp_xlat,
    output logic                  rsp_null,
    output logic                  rsp_inval,
    output logic                  mem_rd_en,
    output logic [VA_W-1:0]       mem_rd_addr,
    input  logic                  mem_rsp_valid,
    input  logic [ENT_W-1:0]      mem_rsp_data
);
    walk_state_e     state_q, state_d;
    tbl_level_e      lvl;
    result_kind_e    kind_q;
    logic [VA_W-1:0] va_q, base_q, out_q;
    logic [VA_W-1:0] fetch_addr, next_base;
    logic [PAT_W-1:0] ent_word;
    logic            seg_hit, ent_inval, ent_null, in_wait, accept;

    always_comb begin
        case (state_q)
            S_L2_FETCH, S_L2_WAIT: lvl = LV_L2;
            S_L1_FETCH, S_L1_WAIT: lvl = LV_L1;
            default:               lvl = LV_L3;
        endcase
    end

    assign in_wait = (state_q == S_L3_WAIT) || (state_q == S_L2_WAIT) || (state_q == S_L1_WAIT);
    assign accept  = (state_q == S_IDLE) && req_valid;

    tx_seg_match #(.VA_W(VA_W), .SEL_W(SEL_W)) u_seg (
        .va(req_addr), .xlat_on(cfg_enable && cfg_tables_virt),
        .sel(cfg_seg_sel), .mask(cfg_seg_mask), .hit(seg_hit)
    );

    tx_fetch_addr #(.VA_W(VA_W), .OFF_W(OFF_W), .L3_W(L3_W), .L2_W(L2_W), .L1_W(L1_W)) u_fetch (
        .lvl(lvl), .root_page(cfg_l3_page), .tbl_base(base_q), .va(va_q), .fetch_addr(fetch_addr)
    );

    tx_entry_check #(.VA_W(VA_W), .PAT_W(PAT_W), .ENT_W(ENT_W), .PG_SH(PG_SH)) u_entry (
        .entry(mem_rsp_data), .is_leaf(lvl == LV_L1), .hi_half(fetch_addr[2]),
        .null_pat(cfg_null_pat), .inval_pat(cfg_inval_pat),
        .word(ent_word), .hit_inval(ent_inval), .hit_null(ent_null), .next_base(next_base)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = seg_hit ? S_L3_FETCH : S_RESP;
            S_L3_FETCH: state_d = S_L3_WAIT;
            S_L3_WAIT:  if (mem_rsp_valid) state_d = (ent_inval || ent_null) ? S_RESP : S_L2_FETCH;
            S_L2_FETCH: state_d = S_L2_WAIT;
            S_L2_WAIT:  if (mem_rsp_valid) state_d = (ent_inval || ent_null) ? S_RESP : S_L1_FETCH;
            S_L1_FETCH: state_d = S_L1_WAIT;
            S_L1_WAIT:  if (mem_rsp_valid) state_d = S_RESP;
            S_RESP:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            base_q <= '0;
            out_q  <= '0;
            kind_q <= RK_PASS;
        end else if (accept) begin
            va_q <= req_addr;
            if (!seg_hit) begin
                kind_q <= RK_PASS;
                out_q  <= req_addr;
            end
        end else if (in_wait && mem_rsp_valid) begin
            if (ent_inval) begin
                kind_q <= RK_INVAL;
                out_q  <= '0;
            end else if (ent_null) begin
                kind_q <= RK_NULL;
                out_q  <= '0;
            end else if (lvl == LV_L1) begin
                kind_q <= RK_XLAT;
                out_q  <= {ent_word, va_q[OFF_W-1:0]};
            end else begin
                base_q <= next_base;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == S_IDLE);
        mem_rd_en   = (state_q == S_L3_FETCH) || (state_q == S_L2_FETCH) || (state_q == S_L1_FETCH);
        mem_rd_addr = fetch_addr;
        rsp_valid   = (state_q == S_RESP);
        rsp_addr    = out_q;
        rsp_pass    = (kind_q == RK_PASS);
        rsp_xlat    = (kind_q == RK_XLAT);
        rsp_null    = (kind_q == RK_NULL);
        rsp_inval   = (kind_q == RK_INVAL);
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);                                  // R10
    AST_RSP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);                                               // R10
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_pass, rsp_xlat, rsp_null, rsp_inval}) == 1); // R10
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);                                               // R11
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_null || rsp_inval) |-> rsp_addr == '0);                // R9
    AST_PASS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_pass |-> $past(req_valid && req_ready));                // R2
    AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && (lvl != LV_L1) |-> mem_rd_addr[2:0] == 3'b000);             // R5

endmodule

// File: tb/tile_xlate_walker_test.sv
`timescale 1ns/1ps
module tile_xlate_walker_test;
    localparam logic [47:0] L3B = 48'h0000_1234_0000;
    localparam logic [47:0] L2R = 48'h0100_0000_0000;
    localparam logic [47:0] L1R = 48'h0200_0000_0000;
    localparam logic [31:0] NPAT = 32'h0000_0FF1;
    localparam logic [31:0] IPAT = 32'h0000_0FF3;
    localparam logic [3:0] K_PASS = 4'b1000, K_XLAT = 4'b0100, K_NULL = 4'b0010, K_INV = 4'b0001;

    logic clk = 0, rst_n = 0;
    logic cfg_enable, cfg_tables_virt;
    logic [31:0] cfg_l3_page, cfg_null_pat, cfg_inval_pat;
    logic [3:0] cfg_seg_sel, cfg_seg_mask;
    logic req_valid, req_ready, rsp_valid, rsp_pass, rsp_xlat, rsp_null, rsp_inval;
    logic [47:0] req_addr, rsp_addr, mem_rd_addr;
    logic mem_rd_en, mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    int checks = 0, errors = 0;
    int rd_cnt, dly_cyc = 0;
    bit long_lat = 0;
    logic [47:0] first_rd;
    bit inj_en = 0;
    logic [47:0] inj_dw;
    logic [63:0] inj_data;

    always #2.5 clk = ~clk;

    tile_xlate_walker uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_tables_virt(cfg_tables_virt),
        .cfg_l3_page(cfg_l3_page), .cfg_seg_sel(cfg_seg_sel), .cfg_seg_mask(cfg_seg_mask),
        .cfg_null_pat(cfg_null_pat), .cfg_inval_pat(cfg_inval_pat),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_pass(rsp_pass), .rsp_xlat(rsp_xlat),
        .rsp_null(rsp_null), .rsp_inval(rsp_inval), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] tile(input int i, input int j, input int k);
        return {4'h5, 9'(i), 9'(j), 10'(k)};
    endfunction
    function automatic logic [47:0] mk(input int t, input int i, input int j, input int k, input int off);
        return {4'(t), 9'(i), 9'(j), 10'(k), 16'(off)};
    endfunction
    function automatic logic [47:0] l2_base(input int i);
        return L2R + (48'(i) << 12);
    endfunction
    function automatic logic [47:0] l1_base(input int i, input int j);
        return L1R + (48'(i * 512 + j) << 12);
    endfunction
    function automatic logic [47:0] l3_ent(input int i);
        return L3B + 48'(i) * 8;
    endfunction
    function automatic logic [47:0] l2_ent(input int i, input int j);
        return l2_base(i) + 48'(j) * 8;
    endfunction
    function automatic logic [47:0] l1_dw(input int i, input int j, input int k);
        return l1_base(i, j) + 48'(k / 2) * 8;
    endfunction

    function automatic logic [63:0] memf(input logic [47:0] a);
        logic [47:0] dw;
        int i, j, k0;
        dw = {a[47:3], 3'b000};
        if (inj_en && dw == inj_dw) return inj_data;
        if (dw >= L3B && dw < L3B + 48'd4096) begin
            i = int'((dw - L3B) >> 3);
            return {16'h0, l2_base(i)};
        end
        if (dw >= L2R && dw < L2R + 48'h20_0000) begin
            i = int'((dw - L2R) >> 12);
            j = int'(dw[11:3]);
            return {16'h0, l1_base(i, j)};
        end
        if (dw >= L1R && dw < L1R + 48'h4000_0000) begin
            i = int'((dw - L1R) >> 21);
            j = int'(dw[20:12]);
            k0 = int'(dw[11:2]);
            return {tile(i, j, k0 + 1), tile(i, j, k0)};
        end
        return 64'h0123_4567_89AB_CDE0;
    endfunction

    // table memory responder
    initial begin
        logic [47:0] ra;
        int d;
        mem_rsp_valid = 0;
        mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_en) begin
                ra = mem_rd_addr;
                rd_cnt++;
                if (rd_cnt == 1) first_rd = ra;
                d = long_lat ? 17 : dly_cyc;
                dly_cyc = (dly_cyc + 1) % 4;
                repeat (d + 1) @(posedge clk);
                #1;
                mem_rsp_valid = 1;
                mem_rsp_data = memf(ra);
                @(posedge clk);
                #1;
                mem_rsp_valid = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic walk(input logic [47:0] a, input logic [3:0] ek, input logic [47:0] ea,
                        input int er, input string tag);
        bit busy_ok;
        int n;
        logic [3:0] gk;
        rd_cnt = 0;
        first_rd = '0;
        @(negedge clk);
        req_addr = a;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        busy_ok = 1;
        n = 0;
        while (!rsp_valid && n < 500) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            n++;
        end
        if (req_ready) busy_ok = 0;
        gk = {rsp_pass, rsp_xlat, rsp_null, rsp_inval};
        chk(rsp_valid && gk == ek && rsp_addr == ea, {tag, " result"}, {12'h0, gk, rsp_addr},
            {12'h0, ek, ea});
        chk(rd_cnt == er, {tag, " read count"}, 64'(rd_cnt), 64'(er));
        if (er > 0)
            chk(first_rd == l3_ent(int'(a[43:35])), "R4 first read address", 64'(first_rd),
                64'(l3_ent(int'(a[43:35]))));
        chk(busy_ok, "R10 ready held low during walk", 64'(busy_ok), 64'd1);
        @(negedge clk);
    endtask

    task automatic xl(input int t, input int i, input int j, input int k, input int off, input string tag);
        walk(mk(t, i, j, k, off), K_XLAT, {tile(i, j, k), 16'(off)}, 3, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int i, j, k;
        logic [47:0] a;
        logic hit;
        cfg_enable = 1; cfg_tables_virt = 1; cfg_l3_page = L3B[47:16];
        cfg_seg_sel = 4'h3; cfg_seg_mask = 4'hF; cfg_null_pat = NPAT; cfg_inval_pat = IPAT;
        req_valid = 0; req_addr = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(mem_rd_en == 0, "R1 mem_rd_en after reset", 64'(mem_rd_en), 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && rsp_valid == 0 && mem_rd_en == 0, "R1 idle after release",
            {req_ready, rsp_valid, mem_rd_en}, 64'h4);

        // R3 full-nibble sweep over every select and every top nibble
        for (int s = 0; s < 16; s++) begin
            cfg_seg_sel = 4'(s);
            for (int t = 0; t < 16; t++) begin
                i = (s * 37 + t * 11) % 512;
                j = (s * 5 + t * 97) % 512;
                k = (s * 61 + t * 29) % 1024;
                a = mk(t, i, j, k, s * 4096 + t * 17);
                if (s == t) xl(t, i, j, k, s * 4096 + t * 17, "R3 R7 hit");
                else walk(a, K_PASS, a, 0, "R3 R2 miss");
            end
        end

        // R3 partial masks
        cfg_seg_sel = 4'b1011;
        for (int m = 0; m < 3; m++) begin
            cfg_seg_mask = (m == 0) ? 4'b1100 : ((m == 1) ? 4'b0001 : 4'b0000);
            for (int t = 0; t < 16; t++) begin
                hit = ((4'(t) & cfg_seg_mask) == (cfg_seg_sel & cfg_seg_mask));
                a = mk(t, t * 7, t * 13, t * 41, t);
                if (hit) xl(t, t * 7, t * 13, t * 41, t, "R3 masked hit");
                else walk(a, K_PASS, a, 0, "R3 masked miss");
            end
        end
        cfg_seg_sel = 4'h3;
        cfg_seg_mask = 4'hF;

        // R5 R6 index corners, both leaf halves
        for (int ci = 0; ci < 2; ci++)
            for (int cj = 0; cj < 2; cj++)
                for (int ck = 0; ck < 4; ck++)
                    xl(3, ci * 511, cj * 511, (ck < 2) ? ck : 1020 + ck, 16'hFFFF - ck,
                       "R5 R6 index corner");

        // R2 disables
        a = mk(3, 10, 20, 30, 40);
        cfg_enable = 0;
        walk(a, K_PASS, a, 0, "R2 enable clear");
        cfg_enable = 1; cfg_tables_virt = 0;
        walk(a, K_PASS, a, 0, "R2 virt clear");
        cfg_tables_virt = 1;

        // R8 invalid at each level
        a = mk(3, 100, 200, 300, 16'h1234);
        inj_en = 1;
        inj_dw = l3_ent(100); inj_data = {32'h0, IPAT};
        walk(a, K_INV, 48'h0, 1, "R8 invalid at top level");
        inj_dw = l2_ent(100, 200);
        walk(a, K_INV, 48'h0, 2, "R8 invalid at mid level");
        inj_dw = l1_dw(100, 200, 300); inj_data = {tile(100, 200, 301), IPAT};
        walk(a, K_INV, 48'h0, 3, "R8 invalid at leaf low half");
        xl(3, 100, 200, 301, 16'h1234, "R6 untouched high half");
        inj_data = {IPAT, tile(100, 200, 300)};
        walk(mk(3, 100, 200, 301, 5), K_INV, 48'h0, 3, "R8 invalid at leaf high half");
        xl(3, 100, 200, 300, 16'h1234, "R6 untouched low half");

        // R9 null at each level
        inj_dw = l3_ent(100); inj_data = {32'h0, NPAT};
        walk(a, K_NULL, 48'h0, 1, "R9 null at top level");
        inj_dw = l2_ent(100, 200);
        walk(a, K_NULL, 48'h0, 2, "R9 null at mid level");
        inj_dw = l1_dw(100, 200, 300); inj_data = {tile(100, 200, 301), NPAT};
        walk(a, K_NULL, 48'h0, 3, "R9 null at leaf");

        // R8 priority when both patterns are the same
        cfg_null_pat = IPAT;
        inj_dw = l2_ent(100, 200); inj_data = {32'h0, IPAT};
        walk(a, K_INV, 48'h0, 2, "R8 invalid wins over null");
        cfg_null_pat = NPAT;
        inj_en = 0;

        // R11 long read latency
        long_lat = 1;
        xl(3, 511, 0, 1023, 16'h8001, "R11 long latency");
        xl(3, 7, 300, 2, 16'h0002, "R11 long latency");
        long_lat = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule